// File: doc/BRIEF.md
# Multi-Pattern Parallel Test Word Generator

This block produces one transmit word per clock for testing a serial link. The word feeds a serializer, and bit 0 of each word is the first bit on the line. A run-time select input picks one of four pseudo-random binary sequences (PRBS) of different lengths, or one of two square-wave patterns. The square waves are a fast one that alternates every bit and a slow one made of ten ones followed by ten zeros. Every bit of a word is computed in the same cycle, so the full width advances by one word per clock.

A small state machine handles the enable and the stall. Its states are `ST_IDLE` (word forced to zero), `ST_RUN` (a new word each cycle) and `ST_HOLD` (last word repeated, sequence frozen). The transitions are:
- `ST_IDLE`→`ST_RUN` when enabled and not stalled.
- `ST_RUN`→`ST_HOLD` on stall.
- `ST_HOLD`→`ST_RUN` when the stall drops.
- `ST_RUN`/`ST_HOLD`→`ST_IDLE` when the enable drops.
- In every other case the state stays where it is.

Each lane of a multi-lane tester uses its own instance of the block.

Top module: `ptn_word_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_word` becomes zero after that edge. Reset loads every LFSR with all ones, clears the square-wave phase and sets the remembered select to 0. After reset, PRBS-7 therefore starts from its seed.
- R2: The `pat_sel` encoding is as follows. 0 selects PRBS-7 (x^7+x^6+1) and 1 selects PRBS-15 (x^15+x^14+1). 2 selects PRBS-23 (x^23+x^18+1) and 3 selects PRBS-31 (x^31+x^28+1). 4 selects the alternating pattern and 5 selects the ten-high/ten-low pattern. 6 and 7 are reserved.
- R3: A PRBS of degree n with second tap t produces the bit b = s[n-1] XOR s[t-1] and then shifts b into s[0]. `tx_word[i]` is the i-th bit produced in that cycle.
- R4: PRBS-7 repeats every 127 bits, so with a 16-bit word the word emitted 127 words after a given word equals that word.
- R5: The alternating pattern starts at 1 on bit 0 after a reseed, and adjacent bits always differ (16'h5555 for a 16-bit word).
- R6: The ten-high/ten-low pattern keeps a phase modulo 20 across words. For a 16-bit word it emits 03FF, 3FF0, FF00, F003, 003F and then repeats.
- R7: When `gen_en` is low at an edge, `tx_word` becomes zero and no sequence advances. Re-enabling resumes at the next unsent word.
- R8: When `gen_en` and `stall` are both high at an edge, `tx_word` keeps its value and no sequence advances.
- R9: Any change of `pat_sel` from the previous cycle reseeds the LFSRs with all ones and clears the phase. The first word after a change is the pattern's first word from its seed.
- R10: A word is registered at the edge where the inputs are sampled (one-cycle latency), and `tx_word` does not change between edges.
- R11: While enabled and not stalled, the reserved codes 6 and 7 produce all-zero words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 3 | Pattern code (see R2) |
| gen_en | input | 1 | Generation enable; low forces zero words |
| stall | input | 1 | Freezes the sequence and repeats the last word |
| tx_word | output | WORD_W | Parallel word; bit 0 is sent first |

## Verification
A wrong LFSR tap or a wrong bit order shows as a mismatch in the very first PRBS word after a reseed. An LFSR that advances during a stall or while disabled shows in the first word after the freeze ends. A phase counter that wraps wrongly breaks the five-word square-wave cycle by its second or third word. A missed reseed shows in the first word after a select change.

// File: rtl/ptn_pkg.sv
package ptn_pkg;

    localparam int PAT_W      = 3;
    localparam int NUM_PRBS   = 4;
    localparam int SQ_PERIOD  = 20;
    localparam int SQ_HIGH    = 10;
    localparam int PHASE_W    = $clog2(SQ_PERIOD);

    typedef enum logic [PAT_W-1:0] {
        PAT_PRBS7  = 3'd0,
        PAT_PRBS15 = 3'd1,
        PAT_PRBS23 = 3'd2,
        PAT_PRBS31 = 3'd3,
        PAT_ALT    = 3'd4,
        PAT_SQ10   = 3'd5,
        PAT_RSV6   = 3'd6,
        PAT_RSV7   = 3'd7
    } pat_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } gen_st_e;

    // degree of the PRBS engine with index k
    function automatic int prbs_len(input int k);
        case (k)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // second feedback exponent of the PRBS engine with index k
    function automatic int prbs_tap(input int k);
        case (k)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/ptn_prbs_word.sv
module ptn_prbs_word #(
    parameter int LEN    = 7,
    parameter int TAP    = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [WORD_W-1:0] word
);

    logic [LEN-1:0]    lfsr_q;
    logic [LEN-1:0]    start_s;
    logic [LEN-1:0]    roll_s;
    logic [LEN-1:0]    end_s;
    logic [WORD_W-1:0] bits_w;

    // Unrolled feedback: WORD_W serial steps per cycle.
    always_comb begin
        start_s = load ? {LEN{1'b1}} : lfsr_q;
        roll_s  = start_s;
        bits_w  = '0;
        for (int b = 0; b < WORD_W; b++) begin
            bits_w[b] = roll_s[LEN-1] ^ roll_s[TAP-1];
            roll_s    = {roll_s[LEN-2:0], bits_w[b]};
        end
        end_s = roll_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= {LEN{1'b1}};
        end else if (step) begin
            lfsr_q <= end_s;
        end else if (load) begin
            lfsr_q <= {LEN{1'b1}};
        end
    end

    assign word = bits_w;

endmodule

// File: rtl/ptn_sq_word.sv
module ptn_sq_word
    import ptn_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [WORD_W-1:0] alt_word,
    output logic [WORD_W-1:0] sq_word
);

    localparam int ADV = WORD_W % SQ_PERIOD;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] cur_ph;
    logic [PHASE_W-1:0] nxt_ph;

    always_comb begin
        int pos;
        int sum;
        cur_ph   = load ? '0 : phase_q;
        alt_word = '0;
        sq_word  = '0;
        for (int b = 0; b < WORD_W; b++) begin
            pos         = (int'(cur_ph) + b) % SQ_PERIOD;
            alt_word[b] = (pos % 2) == 0;
            sq_word[b]  = pos < SQ_HIGH;
        end
        sum = int'(cur_ph) + ADV;
        if (sum >= SQ_PERIOD) begin
            sum = sum - SQ_PERIOD;
        end
        nxt_ph = PHASE_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= nxt_ph;
        end else if (load) begin
            phase_q <= '0;
        end
    end

endmodule

// File: rtl/ptn_ctrl.sv
module ptn_ctrl
    import ptn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gen_en,
    input  logic stall,
    output logic emit,
    output logic clear
);

    gen_st_e st_q;
    gen_st_e st_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (gen_en && !stall) st_nxt = ST_RUN;
            ST_RUN: begin
                if (!gen_en)    st_nxt = ST_IDLE;
                else if (stall) st_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (!gen_en)     st_nxt = ST_IDLE;
                else if (!stall) st_nxt = ST_RUN;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    // output decode
    always_comb begin
        emit  = 1'b0;
        clear = 1'b0;
        unique case (st_nxt)
            ST_IDLE: clear = 1'b1;
            ST_RUN:  emit  = 1'b1;
            ST_HOLD: ;
            default: clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptn_word_gen.sv
module ptn_word_gen
    import ptn_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        pat_sel,
    input  logic              gen_en,
    input  logic              stall,
    output logic [WORD_W-1:0] tx_word
);

    logic [PAT_W-1:0]  sel_q;
    logic              sel_load;
    logic              emit;
    logic              clear;
    logic              sq_step;
    logic [WORD_W-1:0] prbs_w [NUM_PRBS];
    logic [WORD_W-1:0] alt_w;
    logic [WORD_W-1:0] sq_w;
    logic [WORD_W-1:0] pick_w;
    pat_e              sel_e;

    assign sel_e    = pat_e'(pat_sel);
    assign sel_load = (pat_sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= pat_sel;
    end

    ptn_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .gen_en (gen_en),
        .stall  (stall),
        .emit   (emit),
        .clear  (clear)
    );

    for (genvar k = 0; k < NUM_PRBS; k++) begin : g_prbs
        ptn_prbs_word #(
            .LEN    (prbs_len(k)),
            .TAP    (prbs_tap(k)),
            .WORD_W (WORD_W)
        ) u_lfsr (
            .clk  (clk),
            .rst  (rst),
            .load (sel_load),
            .step (emit && (pat_sel == 3'(k))),
            .word (prbs_w[k])
        );
    end

    assign sq_step = emit && ((sel_e == PAT_ALT) || (sel_e == PAT_SQ10));

    ptn_sq_word #(.WORD_W(WORD_W)) u_sq (
        .clk      (clk),
        .rst      (rst),
        .load     (sel_load),
        .step     (sq_step),
        .alt_word (alt_w),
        .sq_word  (sq_w)
    );

    always_comb begin
        unique case (sel_e)
            PAT_PRBS7:  pick_w = prbs_w[0];
            PAT_PRBS15: pick_w = prbs_w[1];
            PAT_PRBS23: pick_w = prbs_w[2];
            PAT_PRBS31: pick_w = prbs_w[3];
            PAT_ALT:    pick_w = alt_w;
            PAT_SQ10:   pick_w = sq_w;
            PAT_RSV6:   pick_w = '0;
            PAT_RSV7:   pick_w = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) tx_word <= '0;
        else if (emit)    tx_word <= pick_w;
    end

endmodule

// File: rtl/ptn_word_gen_chk.sv
module ptn_word_gen_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        pat_sel,
    input logic              gen_en,
    input logic              stall,
    input logic [WORD_W-1:0] tx_word
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tx_word == '0));

    // R7
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (tx_word == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && stall) |=> $stable(tx_word));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && !stall && (pat_sel[2:1] == 2'b11)) |=> (tx_word == '0));

    // R5
    alt_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && !stall && (pat_sel == 3'd4)) |=>
            (&(tx_word[WORD_W-1:1] ^ tx_word[WORD_W-2:0])));

endmodule

bind ptn_word_gen ptn_word_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pat_sel (pat_sel),
    .gen_en  (gen_en),
    .stall   (stall),
    .tx_word (tx_word)
);

// File: tb/tb_ptn_word_gen.sv
`timescale 1ns/1ps
module tb_ptn_word_gen;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   pat_sel;
    logic         gen_en;
    logic         stall;
    logic [W-1:0] tx_word;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    ptn_word_gen #(.WORD_W(W)) dut (
        .clk(clk), .rst(rst), .pat_sel(pat_sel),
        .gen_en(gen_en), .stall(stall), .tx_word(tx_word)
    );

    // reference model state
    logic [30:0]  m_lfsr [4];
    int           m_phase;
    logic [2:0]   m_selq;
    logic [W-1:0] m_exp;

    function automatic int deg(input int k);
        case (k) 0: return 7; 1: return 15; 2: return 23; default: return 31; endcase
    endfunction
    function automatic int tap2(input int k);
        case (k) 0: return 6; 1: return 14; 2: return 18; default: return 28; endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_lfsr[k] = '1;
        m_phase = 0;
        m_selq  = 3'd0;
        m_exp   = '0;
    endtask

    task automatic model_cycle(input logic [2:0] s, input logic en, input logic st);
        int n, t, p;
        logic nb;
        if (s != m_selq) begin
            for (int k = 0; k < 4; k++) m_lfsr[k] = '1;
            m_phase = 0;
        end
        m_selq = s;
        if (!en) begin
            m_exp = '0;
        end else if (!st) begin
            m_exp = '0;
            if (s < 3'd4) begin
                n = deg(int'(s));
                t = tap2(int'(s));
                for (int b = 0; b < W; b++) begin
                    nb = m_lfsr[s][n-1] ^ m_lfsr[s][t-1];
                    m_exp[b] = nb;
                    m_lfsr[s] = {m_lfsr[s][29:0], nb};
                end
            end else if (s == 3'd4 || s == 3'd5) begin
                for (int b = 0; b < W; b++) begin
                    p = (m_phase + b) % 20;
                    m_exp[b] = (s == 3'd4) ? ((p % 2) == 0) : (p < 10);
                end
                m_phase = (m_phase + W) % 20;
            end
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle from a negedge; returns at the next negedge
    task automatic step(input logic r, input logic [2:0] s, input logic en, input logic st);
        rst = r; pat_sel = s; gen_en = en; stall = st;
        if (r) model_reset();
        else   model_cycle(s, en, st);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]   sel;
        logic         en;
        logic         st;
        logic         ev;
        logic [W-1:0] exp;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'h03FF},  // R6 R9
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'h3FF0},  // R6
        '{3'd5, 1'b1, 1'b1, 1'b1, 16'h3FF0},  // R8
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'hFF00},  // R6 R8
        '{3'd5, 1'b0, 1'b0, 1'b1, 16'h0000},  // R7
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'hF003},  // R7 resume
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'h003F},  // R6
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'h03FF},  // R6 wrap
        '{3'd4, 1'b1, 1'b0, 1'b1, 16'h5555},  // R5
        '{3'd4, 1'b1, 1'b0, 1'b1, 16'h5555},  // R5
        '{3'd6, 1'b1, 1'b0, 1'b1, 16'h0000},  // R11
        '{3'd7, 1'b1, 1'b0, 1'b1, 16'h0000},  // R11
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0000},  // R3
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd0, 1'b1, 1'b1, 1'b0, 16'h0000},
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd1, 1'b1, 1'b0, 1'b0, 16'h0000},  // R2
        '{3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{3'd1, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd2, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd2, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{3'd5, 1'b1, 1'b0, 1'b1, 16'h03FF},  // R9 reseed on return
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0000}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] first7, first15;
        rst = 1'b1; pat_sel = 3'd0; gen_en = 1'b0; stall = 1'b0;
        model_reset();
        @(negedge clk);
        step(1'b1, 3'd0, 1'b0, 1'b0);
        step(1'b1, 3'd0, 1'b0, 1'b0);
        check("R1 reset word", tx_word, '0);

        // R10: no change before the edge, new word after it
        rst = 1'b0; pat_sel = 3'd0; gen_en = 1'b1; stall = 1'b0;
        model_cycle(3'd0, 1'b1, 1'b0);
        #1;
        check("R10 before edge", tx_word, '0);
        @(negedge clk);
        check("R3 R10 first PRBS7 word", tx_word, m_exp);
        first7 = tx_word;
        for (int i = 1; i <= 127; i++) begin
            step(1'b0, 3'd0, 1'b1, 1'b0);
            if (i == 1) check("R3 PRBS7 second word", tx_word, m_exp);
        end
        check("R4 PRBS7 period", tx_word, first7);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(1'b0, TBL[i].sel, TBL[i].en, TBL[i].st);
            if (TBL[i].ev) check($sformatf("R6 R5 R7 R8 R11 row %0d", i), tx_word, TBL[i].exp);
            else           check($sformatf("R2 R3 row %0d", i), tx_word, m_exp);
        end

        // R9: switching away and back restarts from the seed
        step(1'b0, 3'd1, 1'b1, 1'b0);
        first15 = tx_word;
        check("R2 PRBS15 first word", tx_word, m_exp);
        step(1'b0, 3'd1, 1'b1, 1'b0);
        step(1'b0, 3'd2, 1'b1, 1'b0);
        step(1'b0, 3'd1, 1'b1, 1'b0);
        check("R9 PRBS15 reseed", tx_word, first15);

        // R9: change while stalled reseeds without emitting
        step(1'b0, 3'd3, 1'b1, 1'b1);
        check("R8 R9 stall across change", tx_word, first15);
        step(1'b0, 3'd3, 1'b1, 1'b0);
        check("R9 PRBS31 first word", tx_word, m_exp);

        // R1: reset mid-run, PRBS7 restarts from the seed
        step(1'b0, 3'd0, 1'b1, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0);
        step(1'b1, 3'd0, 1'b1, 1'b0);
        check("R1 mid-run reset", tx_word, '0);
        step(1'b0, 3'd0, 1'b1, 1'b0);
        check("R1 seed after reset", tx_word, first7);

        // R7: disable mid-PRBS, resume continues
        step(1'b0, 3'd0, 1'b0, 1'b0);
        check("R7 disabled", tx_word, '0);
        step(1'b0, 3'd0, 1'b1, 1'b0);
        check("R7 resume", tx_word, m_exp);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule